// File: doc/BRIEF.md
# Printer Strobe and Drive Indicator Controller

This block sits beside the register file of a sound generator whose two general purpose I/O ports are reused for a parallel printer and for floppy drive selection. It watches every write to the port A register. One bit of port A acts as the printer strobe. When a write takes that bit from high to low, the block captures the current port B byte as a printed character. It then raises a one-cycle data-valid pulse and the matching interrupt request pulses.

Two other port A bits are active-low drive selects. Each one sets a drive activity indicator level. The block only acts on port A writes. Idle cycles, and cycles on which other registers change, leave its stored strobe history and indicator levels as they were.

Top module: `prn_strobe_ctrl`

## Requirements
- R1: After reset, prn_valid, irq_busy, irq_ack, led_drv_a, led_drv_b and prn_data are all 0. The stored previous strobe value is 0, so a first write with bit 5 low starts no transfer.
- R2: A port A write (pa_wr=1) with pa_val bit 5 = 0, made while the stored previous strobe is 1 and print_en=1, sets prn_valid high for exactly the one cycle after the write edge.
- R3: On a transfer, prn_data takes the pb_val byte present in the write cycle.
- R4: irq_busy pulses high in the same cycle as prn_valid, on every transfer.
- R5: irq_ack pulses together with prn_valid only when alt_mode=1 in the write cycle. Otherwise it stays 0.
- R6: With print_en=0 no transfer happens. The stored previous strobe still takes bit 5 of every port A write, so a high write made while printing is disabled arms a later low write made while printing is enabled.
- R7: Port A writes that take bit 5 from low to low, from high to high, or from low to high start no transfer.
- R8: After each port A write, led_drv_a equals the inverse of pa_val bit 1 and led_drv_b equals the inverse of pa_val bit 2. A bit at 0 turns its indicator on.
- R9: Cycles with pa_wr=0 change neither the stored previous strobe nor the indicator levels, whatever pa_val holds.
- R10: prn_data keeps its last captured byte until the next transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa_wr | input | 1 | Port A register write strobe |
| pa_val | input | 8 | Value being written to port A |
| pb_val | input | 8 | Current port B register contents |
| print_en | input | 1 | Printing enabled |
| alt_mode | input | 1 | Alternate machine mode, adds the acknowledge interrupt |
| prn_data | output | 8 | Last byte sent to the printer |
| prn_valid | output | 1 | One-cycle pulse marking a new printer byte |
| irq_busy | output | 1 | Busy interrupt request pulse |
| irq_ack | output | 1 | Acknowledge interrupt request pulse |
| led_drv_a | output | 1 | Drive A activity indicator |
| led_drv_b | output | 1 | Drive B activity indicator |

## Verification
The hardest case to reach from the ports is a transfer whose arming write was made while printing was disabled. This shows that the strobe history keeps updating even when no transfer can fire. The bench writes the strobe high with print_en low, then enables printing and writes the strobe low, and it expects a transfer. It also toggles pa_val with pa_wr held low before a falling write, to show that non-write cycles never disturb the history or the indicators.

// File: rtl/prn_strobe_pkg.sv
package prn_strobe_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              valid;
        logic              busy;
        logic              ack;
        logic [BYTE_W-1:0] data;
    } xfer_t;

    typedef struct packed {
        logic led_a;
        logic led_b;
    } led_t;
endpackage

// File: rtl/strobe_hist.sv
module strobe_hist #(
    parameter int DATA_W     = 8,
    parameter int STROBE_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] val,
    output logic              fall,
    output logic              hist
);
    logic hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (wr) hist_d = val[STROBE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= hist_d;
    end

    assign fall = wr && hist_q && !val[STROBE_BIT];
    assign hist = hist_q;

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(hist_q)); // R9
    AST_HIST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> hist_q == $past(val[STROBE_BIT])); // R6
endmodule

// File: rtl/xfer_emit.sv
module xfer_emit
    import prn_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              alt_mode,
    input  logic [BYTE_W-1:0] pb,
    output xfer_t             xfer
);
    xfer_t x_d, x_q;

    always_comb begin
        x_d       = x_q;
        x_d.valid = fire;
        x_d.busy  = fire;
        x_d.ack   = fire && alt_mode;
        if (fire) x_d.data = pb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign xfer = x_q;

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(x_q.data)); // R10
    AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> x_q.data == $past(pb)); // R3
endmodule

// File: rtl/drive_leds.sv
module drive_leds
    import prn_strobe_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SEL_A_BIT = 1,
    parameter int SEL_B_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] val,
    output led_t              leds
);
    led_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (wr) begin
            l_d.led_a = ~val[SEL_A_BIT];
            l_d.led_b = ~val[SEL_B_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign leds = l_q;

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(l_q)); // R9
    AST_LED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (l_q.led_a != $past(val[SEL_A_BIT])) && (l_q.led_b != $past(val[SEL_B_BIT]))); // R8
endmodule

// File: rtl/prn_strobe_ctrl.sv
module prn_strobe_ctrl
    import prn_strobe_pkg::*;
#(
    parameter int STROBE_BIT = 5,
    parameter int SEL_A_BIT  = 1,
    parameter int SEL_B_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pa_wr,
    input  logic [BYTE_W-1:0] pa_val,
    input  logic [BYTE_W-1:0] pb_val,
    input  logic              print_en,
    input  logic              alt_mode,
    output logic [BYTE_W-1:0] prn_data,
    output logic              prn_valid,
    output logic              irq_busy,
    output logic              irq_ack,
    output logic              led_drv_a,
    output logic              led_drv_b
);
    logic  fall, hist;
    logic  fire;
    xfer_t xfer;
    led_t  leds;

    strobe_hist #(.DATA_W(BYTE_W), .STROBE_BIT(STROBE_BIT)) u_hist (
        .clk(clk), .rst_n(rst_n), .wr(pa_wr), .val(pa_val),
        .fall(fall), .hist(hist)
    );

    assign fire = fall && print_en;

    xfer_emit u_emit (
        .clk(clk), .rst_n(rst_n), .fire(fire), .alt_mode(alt_mode),
        .pb(pb_val), .xfer(xfer)
    );

    drive_leds #(.DATA_W(BYTE_W), .SEL_A_BIT(SEL_A_BIT), .SEL_B_BIT(SEL_B_BIT)) u_leds (
        .clk(clk), .rst_n(rst_n), .wr(pa_wr), .val(pa_val), .leds(leds)
    );

    assign prn_data  = xfer.data;
    assign prn_valid = xfer.valid;
    assign irq_busy  = xfer.busy;
    assign irq_ack   = xfer.ack;
    assign led_drv_a = leds.led_a;
    assign led_drv_b = leds.led_b;

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        prn_valid |=> !prn_valid); // R2
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa_wr && hist && !pa_val[STROBE_BIT]) |=> !prn_valid); // R7
    AST_BUSY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        prn_valid == irq_busy); // R4
    AST_ACK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> irq_busy); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !print_en |=> !prn_valid); // R6
endmodule

// File: tb/sim_prn_strobe_ctrl.sv
module sim_prn_strobe_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pa_wr = 1'b0;
    logic [7:0] pa_val = 8'hFF;
    logic [7:0] pb_val = 8'h00;
    logic       print_en = 1'b0;
    logic       alt_mode = 1'b0;
    logic [7:0] prn_data;
    logic       prn_valid, irq_busy, irq_ack, led_drv_a, led_drv_b;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prn_strobe_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pa_wr(pa_wr), .pa_val(pa_val), .pb_val(pb_val),
        .print_en(print_en), .alt_mode(alt_mode), .prn_data(prn_data),
        .prn_valid(prn_valid), .irq_busy(irq_busy), .irq_ack(irq_ack),
        .led_drv_a(led_drv_a), .led_drv_b(led_drv_b)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one port A write; returns at the negedge after the write edge.
    task automatic wr_pa(input logic [7:0] v);
        @(negedge clk);
        pa_wr  = 1'b1;
        pa_val = v;
        @(negedge clk);
        pa_wr  = 1'b0;
    endtask

    task automatic chk_pulse(input string req, input logic v, input logic b, input logic a);
        chk({req, " valid"}, {7'd0, prn_valid}, {7'd0, v});
        chk({req, " busy"},  {7'd0, irq_busy},  {7'd0, b});
        chk({req, " ack"},   {7'd0, irq_ack},   {7'd0, a});
    endtask

    task automatic t_reset;
        chk_pulse("R1 reset", 1'b0, 1'b0, 1'b0);
        chk("R1 data", prn_data, 8'h00);
        chk("R1 leds", {6'd0, led_drv_a, led_drv_b}, 8'h00);
        print_en = 1'b1;
        pb_val   = 8'h11;
        wr_pa(8'h06); // strobe low first write
        chk_pulse("R1 first low write", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_basic;
        wr_pa(8'h26); // strobe high
        pb_val = 8'h41;
        wr_pa(8'h06); // falling
        chk_pulse("R2 R4 transfer", 1'b1, 1'b1, 1'b0);
        chk("R3 data", prn_data, 8'h41);
        @(negedge clk);
        chk_pulse("R2 pulse width", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_alt;
        alt_mode = 1'b1;
        wr_pa(8'h26);
        pb_val = 8'h5A;
        wr_pa(8'h06);
        chk_pulse("R5 alt transfer", 1'b1, 1'b1, 1'b1);
        chk("R3 alt data", prn_data, 8'h5A);
        alt_mode = 1'b0;
    endtask

    task automatic t_disabled;
        print_en = 1'b0;
        wr_pa(8'h26);
        pb_val = 8'h77;
        wr_pa(8'h06);
        chk_pulse("R6 disabled fall", 1'b0, 1'b0, 1'b0);
        chk("R6 data unchanged", prn_data, 8'h5A);
        wr_pa(8'h26); // arm while disabled
        print_en = 1'b1;
        pb_val = 8'h3C;
        wr_pa(8'h06);
        chk_pulse("R6 armed while disabled", 1'b1, 1'b1, 1'b0);
        chk("R6 data", prn_data, 8'h3C);
    endtask

    task automatic t_no_edge;
        pb_val = 8'h99;
        wr_pa(8'h06); // low->low
        chk_pulse("R7 low-low", 1'b0, 1'b0, 1'b0);
        wr_pa(8'h26); // low->high
        chk_pulse("R7 low-high", 1'b0, 1'b0, 1'b0);
        wr_pa(8'h26); // high->high
        chk_pulse("R7 high-high", 1'b0, 1'b0, 1'b0);
        chk("R10 data held", prn_data, 8'h3C);
        wr_pa(8'h06); // tidy: falling, consumes the arm
        chk("R3 R10 data update", prn_data, 8'h99);
    endtask

    task automatic t_leds;
        wr_pa(8'h00);
        chk("R8 both on", {6'd0, led_drv_a, led_drv_b}, 8'h03);
        wr_pa(8'h04); // bit2 high -> B off
        chk("R8 A on", {6'd0, led_drv_a, led_drv_b}, 8'h02);
        wr_pa(8'h02); // bit1 high -> A off
        chk("R8 B on", {6'd0, led_drv_a, led_drv_b}, 8'h01);
        wr_pa(8'hFF);
        chk("R8 both off", {6'd0, led_drv_a, led_drv_b}, 8'h00);
    endtask

    task automatic t_no_write;
        // history is high (last write 0xFF); idle cycles with strobe low must not disarm
        @(negedge clk);
        pa_val = 8'h00;
        @(negedge clk);
        pa_val = 8'h20;
        @(negedge clk);
        chk("R9 leds steady", {6'd0, led_drv_a, led_drv_b}, 8'h00);
        chk_pulse("R9 no pulse", 1'b0, 1'b0, 1'b0);
        pb_val = 8'hC3;
        wr_pa(8'hDF); // falling from stored high
        chk_pulse("R9 history kept", 1'b1, 1'b1, 1'b0);
        chk("R9 data", prn_data, 8'hC3);
        chk("R8 leds after", {6'd0, led_drv_a, led_drv_b}, 8'h00);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_alt();
        t_disabled();
        t_no_edge();
        t_leds();
        t_no_write();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule